// File: doc/BRIEF.md
# Idle Retention Delay Controller

This block sits beside a processor core and decides when the core may be placed in a low-leakage retention state, and whether it wants to be powered down, while it waits in an idle state. Software programs a 32-bit control word with two 3-bit delay codes, one for wait-for-interrupt idle and one for wait-for-event idle, and a power-down enable flag. A write is accepted only when a permission input from a higher privilege level is high. A refused write leaves the word unchanged and raises a one-cycle trap flag.

When the core enters an idle state, the block latches the delay code that belongs to that idle type. It then counts strobes from the system counter, not core clocks. After the selected number of strobes it raises a retention-allowed hint and lets the power controller's retention request through as an acceptance. When the core leaves the idle state, every hint and the acceptance drop in that same cycle, and the count restarts from zero at the next entry.

Top module: `ret_delay_ctrl`

## Requirements
- R1: The control word reads back with the WFE delay code in bits [9:7], the WFI delay code in bits [6:4] and the power-down enable in bit 0. Every other bit always reads as 0, whatever was written to it.
- R2: After reset the control word is 0, the trap flag is 0, ret_accept is 0, and pactive is 3'b001.
- R3: Delay codes 1 to 7 select 2, 8, 32, 64, 128, 256 and 512 tick strobes. Retention-allowed (pactive[1]) rises in the cycle after the strobe that completes the count.
- R4: Only a tick strobe advances the count, and only while idle. A strobe in the same cycle as idle entry is not counted, and retention-allowed is never high before the selected count is reached.
- R5: ret_accept equals ret_req while retention-allowed is high, and is 0 otherwise.
- R6: pactive[2] (power-down wanted) is high while idle only if the entry was a WFI entry (idle_is_wfe=0) with the power-down enable at 1 at that moment. A WFE entry never requests power-down.
- R7: The delay code is taken from the control word in the cycle of idle entry. Writes made while idle do not change the count in progress.
- R8: A write with wr_permit=0 leaves the control word unchanged, and trap_pulse is 1 for exactly the following cycle. A write with wr_permit=1 updates the word at the next edge and raises no trap.
- R9: An idle_exit while idle drops pactive[2:1] and ret_accept in the same cycle and clears the count. The next entry counts from zero.
- R10: pactive[0] (stay on) is the inverse of retention-allowed. It is high whenever the core is not idle or the delay has not yet been reached.
- R11: With delay code 0 for the active idle type, retention-allowed never rises, however many strobes arrive.
- R12: Once reached, the count saturates. Retention-allowed stays high through further strobes until exit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Control word write strobe |
| reg_wr_data | input | 32 | Write data |
| wr_permit | input | 1 | Write permission from higher privilege level |
| reg_rd_data | output | 32 | Control word read value |
| trap_pulse | output | 1 | One-cycle flag after a refused write |
| idle_enter | input | 1 | Core enters idle |
| idle_is_wfe | input | 1 | Idle entry cause: 1 = WFE, 0 = WFI |
| idle_exit | input | 1 | Core leaves idle |
| tick | input | 1 | System counter tick strobe |
| ret_req | input | 1 | Retention request from power controller |
| pactive | output | 3 | [0] stay on, [1] retention allowed, [2] power down wanted |
| ret_accept | output | 1 | Retention request accepted |

## Verification
The hardest case to reach is the saturated end of the longest delay. After 512 strobes, further strobes must leave the hint high, and an exit that coincides with a held retention request must withdraw the acceptance in that same cycle. The bench holds the strobe high for long runs to reach that count, then drives the exit while ret_req is still high. A second hard case is a permitted write that changes the active delay code in the middle of an idle period. The stimulus makes that write between strobes and checks that the count still follows the code latched at entry.

// File: rtl/rdc_pkg.sv
package rdc_pkg;
  localparam int REG_W   = 32;
  localparam int CODE_W  = 3;
  localparam int CNT_W   = 10;
  localparam int WFE_LSB = 7;
  localparam int WFI_LSB = 4;
  localparam int PD_BIT  = 0;
  localparam int SYNC_STAGES = 2;

  localparam logic [REG_W-1:0] CODE_ONES = REG_W'((1 << CODE_W) - 1);
  localparam logic [REG_W-1:0] WR_MASK =
    (CODE_ONES << WFE_LSB) | (CODE_ONES << WFI_LSB) | (REG_W'(1) << PD_BIT);

  // Nonlinear code to tick-count mapping; code 0 means retention disabled
  function automatic logic [CNT_W-1:0] delay_ticks(input logic [CODE_W-1:0] code);
    int c;
    c = int'(code);
    if (c == 0)      return '0;
    else if (c <= 3) return CNT_W'(1) << (2 * c - 1);
    else             return CNT_W'(1) << (c + 2);
  endfunction
endpackage

// File: rtl/rdc_rst_sync.sv
module rdc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/rdc_cfg_reg.sv
module rdc_cfg_reg
  import rdc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [REG_W-1:0]  wr_data,
  input  logic              permit,
  output logic [REG_W-1:0]  rd_data,
  output logic              trap,
  output logic [CODE_W-1:0] wfi_code,
  output logic [CODE_W-1:0] wfe_code,
  output logic              pd_en
);
  logic [REG_W-1:0] cfg_q, cfg_d;
  logic             trap_q, trap_d;
  logic             cfg_en;

  always_comb begin
    cfg_en = wr_en && permit;
    cfg_d  = wr_data & WR_MASK;
    trap_d = wr_en && !permit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= '0;
      trap_q <= 1'b0;
    end else begin
      trap_q <= trap_d;
      if (cfg_en) cfg_q <= cfg_d;
    end
  end

  assign rd_data  = cfg_q;
  assign trap     = trap_q;
  assign wfi_code = cfg_q[WFI_LSB +: CODE_W];
  assign wfe_code = cfg_q[WFE_LSB +: CODE_W];
  assign pd_en    = cfg_q[PD_BIT];

  // R8
  denied_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !permit) |=> ($stable(cfg_q) && trap_q));
endmodule

// File: rtl/rdc_idle_timer.sv
module rdc_idle_timer
  import rdc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              idle_enter,
  input  logic              idle_is_wfe,
  input  logic              idle_exit,
  input  logic              tick,
  input  logic [CODE_W-1:0] wfi_code,
  input  logic [CODE_W-1:0] wfe_code,
  input  logic              pd_en,
  output logic              idle,
  output logic              ready,
  output logic              pd_want
);
  logic             idle_q, idle_d;
  logic             pd_q, pd_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] tgt_q, tgt_d;
  logic             enter_ev, exit_ev, count_ev, upd_en;
  logic [CODE_W-1:0] sel_code;

  always_comb begin
    sel_code = idle_is_wfe ? wfe_code : wfi_code;
    exit_ev  = idle_q && idle_exit;
    enter_ev = !idle_q && idle_enter;
    count_ev = idle_q && tick && (tgt_q != '0) && (cnt_q != tgt_q);
    upd_en   = exit_ev || enter_ev || count_ev;
    idle_d = idle_q;
    pd_d   = pd_q;
    cnt_d  = cnt_q;
    tgt_d  = tgt_q;
    if (exit_ev) begin
      idle_d = 1'b0;
      pd_d   = 1'b0;
      cnt_d  = '0;
    end else if (enter_ev) begin
      idle_d = 1'b1;
      pd_d   = !idle_is_wfe && pd_en;
      cnt_d  = '0;
      tgt_d  = delay_ticks(sel_code);
    end else if (count_ev) begin
      cnt_d  = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idle_q <= 1'b0;
      pd_q   <= 1'b0;
      cnt_q  <= '0;
      tgt_q  <= '0;
    end else if (upd_en) begin
      idle_q <= idle_d;
      pd_q   <= pd_d;
      cnt_q  <= cnt_d;
      tgt_q  <= tgt_d;
    end
  end

  assign idle    = idle_q;
  assign ready   = idle_q && (tgt_q != '0) && (cnt_q == tgt_q);
  assign pd_want = idle_q && pd_q;

  // R12
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= tgt_q);
  // R7
  code_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_q && !idle_exit) |=> $stable(tgt_q));
  // R4
  ready_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> $past(tick));
  // R9
  exit_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_q && idle_exit) |=> (!idle_q && cnt_q == '0));
endmodule

// File: rtl/ret_delay_ctrl.sv
module ret_delay_ctrl
  import rdc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_en,
  input  logic [REG_W-1:0]  reg_wr_data,
  input  logic              wr_permit,
  output logic [REG_W-1:0]  reg_rd_data,
  output logic              trap_pulse,
  input  logic              idle_enter,
  input  logic              idle_is_wfe,
  input  logic              idle_exit,
  input  logic              tick,
  input  logic              ret_req,
  output logic [2:0]        pactive,
  output logic              ret_accept
);
  logic              rst_i_n;
  logic [CODE_W-1:0] wfi_code, wfe_code;
  logic              pd_en;
  logic              idle, ready, pd_want;
  logic              ret_ok, pd_ok;

  rdc_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_i_n)
  );

  rdc_cfg_reg u_cfg (
    .clk(clk), .rst_n(rst_i_n), .wr_en(reg_wr_en), .wr_data(reg_wr_data),
    .permit(wr_permit), .rd_data(reg_rd_data), .trap(trap_pulse),
    .wfi_code(wfi_code), .wfe_code(wfe_code), .pd_en(pd_en)
  );

  rdc_idle_timer u_tmr (
    .clk(clk), .rst_n(rst_i_n), .idle_enter(idle_enter),
    .idle_is_wfe(idle_is_wfe), .idle_exit(idle_exit), .tick(tick),
    .wfi_code(wfi_code), .wfe_code(wfe_code), .pd_en(pd_en),
    .idle(idle), .ready(ready), .pd_want(pd_want)
  );

  // Exit withdraws hints in the same cycle, ahead of the registered state
  always_comb begin
    ret_ok     = ready && !idle_exit;
    pd_ok      = pd_want && !idle_exit;
    pactive    = {pd_ok, ret_ok, !ret_ok};
    ret_accept = ret_ok && ret_req;
  end

  // R5
  accept_gate_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    ret_accept |-> (pactive[1] && ret_req));
  // R6
  pd_idle_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    pactive[2] |-> idle);
  // R10
  stay_on_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    $onehot(pactive[1:0]));
endmodule

// File: tb/sim_ret_delay_ctrl.sv
module sim_ret_delay_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr_en = 1'b0;
  logic [31:0] reg_wr_data = '0;
  logic        wr_permit = 1'b0;
  logic [31:0] reg_rd_data;
  logic        trap_pulse;
  logic        idle_enter = 1'b0;
  logic        idle_is_wfe = 1'b0;
  logic        idle_exit = 1'b0;
  logic        tick = 1'b0;
  logic        ret_req = 1'b0;
  logic [2:0]  pactive;
  logic        ret_accept;

  int n_chk = 0;
  int n_fail = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  ret_delay_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_wr_data(reg_wr_data),
    .wr_permit(wr_permit), .reg_rd_data(reg_rd_data), .trap_pulse(trap_pulse),
    .idle_enter(idle_enter), .idle_is_wfe(idle_is_wfe), .idle_exit(idle_exit),
    .tick(tick), .ret_req(ret_req), .pactive(pactive), .ret_accept(ret_accept)
  );

  // Behavioural reference model
  int  m_reg, m_cnt, m_tgt;
  bit  m_idle, m_pd, m_trap;

  function automatic int ticks_for(input int code);
    case (code)
      1: return 2;
      2: return 8;
      3: return 32;
      4: return 64;
      5: return 128;
      6: return 256;
      7: return 512;
      default: return 0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_reg = 0; m_cnt = 0; m_tgt = 0; m_idle = 0; m_pd = 0; m_trap = 0;
    end else begin
      m_trap = reg_wr_en && !wr_permit;
      if (m_idle && idle_exit) begin
        m_idle = 0; m_cnt = 0; m_pd = 0;
      end else if (!m_idle && idle_enter) begin
        m_idle = 1; m_cnt = 0;
        m_tgt = ticks_for(idle_is_wfe ? (m_reg >> 7) & 7 : (m_reg >> 4) & 7);
        m_pd = !idle_is_wfe && (m_reg & 1);
      end else if (m_idle && tick && m_tgt != 0 && m_cnt < m_tgt) begin
        m_cnt = m_cnt + 1;
      end
      if (reg_wr_en && wr_permit) m_reg = reg_wr_data & 32'h0000_03F1;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      bit rdy;
      rdy = m_idle && m_tgt != 0 && m_cnt == m_tgt && !idle_exit;
      chk(reg_rd_data == m_reg, "R1 model rd_data", reg_rd_data, m_reg);
      chk(trap_pulse == m_trap, "R8 model trap", trap_pulse, m_trap);
      chk(pactive[1] == rdy, "R4 model ret-allowed", pactive[1], rdy);
      chk(pactive[0] == !rdy, "R10 model stay-on", pactive[0], !rdy);
      chk(pactive[2] == (m_idle && m_pd && !idle_exit), "R6 model pd",
          pactive[2], m_idle && m_pd && !idle_exit);
      chk(ret_accept == (rdy && ret_req), "R5 model accept", ret_accept, rdy && ret_req);
    end
  end

  task automatic cyc(input int n = 1);
    repeat (n) begin @(negedge clk); #1; end
  endtask

  task automatic wr(input logic [31:0] d, input bit perm);
    reg_wr_en = 1; reg_wr_data = d; wr_permit = perm;
    cyc();
    reg_wr_en = 0; wr_permit = 0;
  endtask

  task automatic ticks(input int n);
    tick = 1; cyc(n); tick = 0;
  endtask

  task automatic enter(input bit wfe, input bit with_tick);
    idle_enter = 1; idle_is_wfe = wfe; tick = with_tick;
    cyc();
    idle_enter = 0; tick = 0;
  endtask

  task automatic leave();
    idle_exit = 1; cyc(); idle_exit = 0;
  endtask

  initial begin
    cyc(3);
    rst_n = 1;
    cyc(4);
    // R2
    chk(reg_rd_data == 0, "R2 reset rd", reg_rd_data, 0);
    chk(pactive == 3'b001, "R2 reset pactive", pactive, 3'b001);
    chk(ret_accept == 0 && trap_pulse == 0, "R2 reset accept/trap", {ret_accept, trap_pulse}, 0);

    // R1: reserved bits read as zero
    wr(32'hFFFF_FFFF, 1);
    chk(reg_rd_data == 32'h3F1, "R1 mask", reg_rd_data, 32'h3F1);
    // R8: denied write
    wr(32'h0, 0);
    chk(trap_pulse == 1, "R8 trap raised", trap_pulse, 1);
    chk(reg_rd_data == 32'h3F1, "R8 word unchanged", reg_rd_data, 32'h3F1);
    cyc();
    chk(trap_pulse == 0, "R8 trap one cycle", trap_pulse, 0);

    // WFI code 1 (2 ticks), WFE code 2 (8 ticks), pd enabled
    wr(32'h111, 1);
    chk(trap_pulse == 0, "R8 permitted no trap", trap_pulse, 0);
    ret_req = 1;
    enter(0, 1);   // R4: tick in entry cycle ignored
    chk(pactive == 3'b101, "R6 pd on WFI", pactive, 3'b101);
    ticks(1);
    chk(pactive[1] == 0 && ret_accept == 0, "R4 early refused", {pactive[1], ret_accept}, 0);
    ticks(1);
    chk(pactive == 3'b110, "R3 code1 ready", pactive, 3'b110);
    chk(ret_accept == 1, "R5 accept", ret_accept, 1);
    ticks(5);
    chk(pactive[1] == 1, "R12 holds", pactive[1], 1);
    idle_exit = 1; #0;
    chk(pactive == 3'b001 && ret_accept == 0, "R9 same-cycle drop", {pactive, ret_accept}, 4'b0010);
    cyc(); idle_exit = 0;

    // WFE, code changed mid-idle
    enter(1, 0);
    chk(pactive == 3'b001, "R6 no pd on WFE", pactive, 3'b001);
    wr(32'h091, 1);
    ticks(2);
    chk(pactive[1] == 0, "R7 latched code", pactive[1], 0);
    ticks(5);
    chk(pactive[1] == 0, "R3 code2 7 ticks", pactive[1], 0);
    ticks(1);
    chk(pactive[1] == 1, "R7 code2 8 ticks", pactive[1], 1);
    leave();
    // R9: re-entry counts from zero
    enter(1, 0);
    ticks(1);
    chk(pactive[1] == 0, "R9 restart", pactive[1], 0);
    ticks(1);
    chk(pactive[1] == 1, "R9 new code1", pactive[1], 1);
    leave();

    // R11: code 0
    wr(32'h001, 1);
    enter(0, 0);
    ticks(40);
    chk(pactive == 3'b101 && ret_accept == 0, "R11 disabled", {pactive, ret_accept}, 4'b1010);
    leave();

    // Longest delay, saturation, exit with request held
    wr(32'h380, 1);
    enter(1, 0);
    ticks(511);
    chk(pactive[1] == 0, "R3 code7 511", pactive[1], 0);
    ticks(1);
    chk(pactive[1] == 1 && ret_accept == 1, "R3 code7 512", {pactive[1], ret_accept}, 2'b11);
    ticks(20);
    chk(pactive[1] == 1, "R12 saturate", pactive[1], 1);
    idle_exit = 1; #0;
    chk(ret_accept == 0, "R9 accept withdrawn", ret_accept, 0);
    cyc(); idle_exit = 0; ret_req = 0;
    cyc(3);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog act=%0d exp=0", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end
endmodule